// File: doc/BRIEF.md
# Serial Register Port with Run-Time Bit Order

This block is a slave port for a synchronous serial bus. It gives an external controller write and read access to a byte-wide register file inside the block. The active-low chip select frames each access. A frame opens with one instruction byte, which names the direction and the starting register. Any number of data bytes follow, and the register address advances by one after each data byte.

Both the instruction byte and the data bytes are shifted in the bit order held in one control register. That order is either most significant bit first or least significant bit first. The same control register chooses where read data leaves the block:
- 3-wire mode: read data goes out on the shared data line, and its output enable is driven.
- 4-wire mode: read data goes out on a dedicated output pin.

A changed setting takes effect at the start of the next frame. The serial clock, chip select and data input are synchronised into the system clock domain, and their edges are detected there. The serial clock may idle high or low between frames.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every register reads 0x00, the port uses MSB-first order and 3-wire mode, and `sdio_oe` and `sdo` are 0.
- R2: Instruction byte: bit 7 = 1 selects a read and 0 a write, bits 5..0 give the start address, and bit 6 has no effect.
- R3: Bit 1 of the control register at address 0x20 selects the order for instruction and data bytes alike: 1 = LSB first, 0 = MSB first.
- R4: A write to the control register takes effect from the next chip-select frame. The rest of the current frame keeps the old order and mode.
- R5: Writes and reads cover one or more bytes. The address increments after each data byte and wraps from 0x3F to 0x00.
- R6: In 3-wire mode (bit 0 of register 0x20 = 0), read data appears on `sdio_o`. `sdio_oe` is 1 only in the data phase of a read frame.
- R7: In 4-wire mode (bit 0 of register 0x20 = 1), read data appears on `sdo` and `sdio_oe` stays 0.
- R8: Input bits are taken on the rising serial clock edge. Output bits change only on falling serial clock edges.
- R9: Raising chip select ends the frame. A partial byte is discarded, and the bit and byte state restarts at the next frame.
- R10: Frames work the same with the serial clock idling high or idling low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Serial data in |
| sdio_o | output | 1 | Serial data out on the shared line (3-wire) |
| sdio_oe | output | 1 | Output enable for the shared line |
| sdo | output | 1 | Dedicated serial data out (4-wire) |

## Verification
The hardest case to reach is R4: a frame that rewrites the control register and then carries further bytes in the same frame. Only the old order decodes those bytes correctly. The bench writes two bytes starting at 0x20, so the second byte lands in 0x21 under the old order. It then reads 0x21 back in the next frame under the new order and with the opposite clock idle level. Aborts are placed after three instruction bits and after four data bits, so that a counter that fails to restart would misalign every later frame.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int BYTE_W     = 8;
   localparam int CNT_W      = $clog2(BYTE_W);
   localparam int RD_FLAG    = 7;
   localparam int CFG_LSB    = 1;
   localparam int CFG_4WIRE  = 0;

   typedef enum logic {
      PH_INSTR = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("srp_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[gi] <= RST_VAL;
            else if (gi == 0)
               chain[gi] <= d;
            else
               chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile import srp_pkg::*; #(
   parameter int ADDR_W    = 6,
   parameter int CTRL_ADDR = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata,
   output logic              cfg_lsb,
   output logic              cfg_4w
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (CTRL_ADDR >= DEPTH) begin : g_bad
         $error("control address outside register file");
      end
   endgenerate

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata   = mem[raddr];
   assign cfg_lsb = mem[CTRL_ADDR][CFG_LSB];
   assign cfg_4w  = mem[CTRL_ADDR][CFG_4WIRE];
endmodule

// File: rtl/srp_engine.sv
module srp_engine import srp_pkg::*; #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_s,
   input  logic              din_s,
   input  logic              cfg_lsb,
   input  logic              cfg_4w,
   input  logic [BYTE_W-1:0] rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [BYTE_W-1:0] wdata,
   output logic              bit_q,
   output logic              oe_q,
   output logic              four_q
);
   generate
      if (ADDR_W > RD_FLAG - 1 || ADDR_W < 1) begin : g_bad
         $error("address field must fit below the reserved instruction bit");
      end
   endgenerate

   logic              sclk_d, rise, fall, last;
   logic [CNT_W-1:0]  bit_cnt;
   phase_e            phase;
   logic              is_rd, lsb_f;
   logic [ADDR_W-1:0] addr;
   logic [BYTE_W-1:0] sh, tx, nb;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;
   assign last = (bit_cnt == CNT_W'(BYTE_W-1));
   assign nb   = lsb_f ? {din_s, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], din_s};

   assign raddr = (phase == PH_INSTR) ? nb[ADDR_W-1:0] : addr + 1'b1;
   assign we    = rise & ~cs_s & last & (phase == PH_DATA) & ~is_rd;
   assign waddr = addr;
   assign wdata = nb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         phase   <= PH_INSTR;
         is_rd   <= 1'b0;
         lsb_f   <= 1'b0;
         four_q  <= 1'b0;
         addr    <= '0;
         sh      <= '0;
         tx      <= '0;
         bit_q   <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (cs_s) begin
            bit_cnt <= '0;
            phase   <= PH_INSTR;
            is_rd   <= 1'b0;
            oe_q    <= 1'b0;
            bit_q   <= 1'b0;
            lsb_f   <= cfg_lsb;
            four_q  <= cfg_4w;
         end else if (rise) begin
            sh      <= nb;
            bit_cnt <= bit_cnt + 1'b1;
            if (last) begin
               tx <= rdata;
               if (phase == PH_INSTR) begin
                  phase <= PH_DATA;
                  is_rd <= nb[RD_FLAG];
                  addr  <= nb[ADDR_W-1:0];
               end else begin
                  addr  <= addr + 1'b1;
               end
            end
         end else if (fall && phase == PH_DATA && is_rd) begin
            bit_q <= lsb_f ? tx[0] : tx[BYTE_W-1];
            tx    <= lsb_f ? {1'b0, tx[BYTE_W-1:1]} : {tx[BYTE_W-2:0], 1'b0};
            oe_q  <= ~four_q;
         end
      end
   end

   // R9
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (bit_cnt == '0 && phase == PH_INSTR && !oe_q));

   // R4
   order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> ($stable(lsb_f) && $stable(four_q)));

   // R8
   out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && !fall) |=> $stable(bit_q));

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !cs_s && last && phase == PH_DATA) |=> (addr == $past(addr) + 1'b1));

   // R6
   oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (phase == PH_DATA && is_rd));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port import srp_pkg::*; #(
   parameter int ADDR_W      = 6,
   parameter int CTRL_ADDR   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdio_i,
   output logic sdio_o,
   output logic sdio_oe,
   output logic sdo
);
   logic              sclk_s, cs_s, din_s;
   logic              cfg_lsb, cfg_4w;
   logic [ADDR_W-1:0] raddr, waddr;
   logic [BYTE_W-1:0] rdata, wdata;
   logic              we, bit_q, oe_q, four_q;

   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(sdio_i), .q(din_s));

   srp_regfile #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(rdata), .cfg_lsb(cfg_lsb), .cfg_4w(cfg_4w));

   srp_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .din_s(din_s),
      .cfg_lsb(cfg_lsb), .cfg_4w(cfg_4w), .rdata(rdata), .raddr(raddr),
      .we(we), .waddr(waddr), .wdata(wdata), .bit_q(bit_q), .oe_q(oe_q),
      .four_q(four_q));

   assign sdio_o  = bit_q;
   assign sdio_oe = oe_q;
   assign sdo     = bit_q & four_q;

   // R7
   four_wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      four_q |-> !sdio_oe);
endmodule

// File: tb/ser_reg_port_tb_top.sv
module ser_reg_port_tb_top;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
   logic sdio_o, sdio_oe, sdo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] mdl [64];
   bit m_lsb = 1'b0, m_four = 1'b0;
   logic [7:0] wq [$];

   always #10 clk = ~clk;

   ser_reg_port dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo));

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic xfer_byte(input logic [7:0] tx, input bit rdph,
                            input logic [7:0] exp, input string req);
      for (int i = 0; i < 8; i++) begin
         int idx;
         logic lo, hi, oe;
         idx = m_lsb ? i : 7 - i;
         sclk = 1'b0; sdio_i = rdph ? 1'b0 : tx[idx];
         wait_clk(H);
         lo = m_four ? sdo : sdio_o;
         oe = sdio_oe;
         sclk = 1'b1;
         wait_clk(H);
         hi = m_four ? sdo : sdio_o;
         if (rdph) begin
            chk(lo == exp[idx], req, "read bit", lo, exp[idx]);
            chk(hi == lo, "R8", "output moved on rising edge", hi, lo);
            chk(oe == !m_four, m_four ? "R7" : "R6", "sdio_oe in read", oe, !m_four);
         end else begin
            chk(oe == 1'b0, "R6", "sdio_oe outside read data", oe, 0);
         end
      end
   endtask

   task automatic frame(input bit rd, input bit rsv, input logic [5:0] addr,
                        input int n, input bit idle_high, input string req);
      logic [7:0] ins;
      ins = {rd, rsv, addr};
      sclk = idle_high;
      wait_clk(4);
      cs_n = 1'b0;
      wait_clk(4);
      xfer_byte(ins, 1'b0, 8'h00, req);
      for (int k = 0; k < n; k++) begin
         if (rd) xfer_byte(8'h00, 1'b1, mdl[6'(addr + k)], req);
         else    xfer_byte(wq[k], 1'b0, 8'h00, req);
      end
      if (!idle_high) sclk = 1'b0;
      wait_clk(4);
      cs_n = 1'b1;
      if (!rd) for (int k = 0; k < n; k++) mdl[6'(addr + k)] = wq[k];
      wq.delete();
      m_lsb  = mdl[32][1];
      m_four = mdl[32][0];
      wait_clk(8);
   endtask

   task automatic abort_frame(input logic [7:0] ins, input int nbits, input logic [7:0] dat);
      sclk = 1'b0;
      wait_clk(4);
      cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < nbits; i++) begin
         int idx;
         logic b;
         idx = m_lsb ? (i % 8) : 7 - (i % 8);
         b = (i < 8) ? ins[idx] : dat[idx];
         sclk = 1'b0; sdio_i = b; wait_clk(H);
         sclk = 1'b1; wait_clk(H);
      end
      sclk = 1'b0;
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1: idle outputs and reset contents
      chk(sdio_oe == 1'b0, "R1", "sdio_oe after reset", sdio_oe, 0);
      chk(sdo == 1'b0, "R1", "sdo after reset", sdo, 0);
      frame(1'b1, 1'b0, 6'h20, 1, 1'b0, "R1");
      frame(1'b1, 1'b0, 6'h05, 2, 1'b0, "R1");

      // R2, R5: two-byte write and read back, MSB first
      wq.push_back(8'hA5); wq.push_back(8'h3C);
      frame(1'b0, 1'b0, 6'h05, 2, 1'b0, "R5");
      frame(1'b1, 1'b0, 6'h05, 2, 1'b0, "R5");

      // R2: reserved bit 6 set has no effect
      wq.push_back(8'h11);
      frame(1'b0, 1'b1, 6'h07, 1, 1'b0, "R2");
      frame(1'b1, 1'b1, 6'h07, 1, 1'b0, "R2");

      // R9: aborted data byte and aborted instruction leave state intact
      abort_frame(8'h07, 12, 8'hFF);
      abort_frame(8'h87, 3, 8'h00);
      frame(1'b1, 1'b0, 6'h07, 1, 1'b0, "R9");

      // R5: address wrap from 0x3F to 0x00
      wq.push_back(8'h5A); wq.push_back(8'hE1);
      frame(1'b0, 1'b0, 6'h3F, 2, 1'b1, "R5");
      frame(1'b1, 1'b0, 6'h3F, 2, 1'b1, "R5");

      // R4: switch to LSB first; byte for 0x21 still MSB first in this frame
      wq.push_back(8'h02); wq.push_back(8'h81);
      frame(1'b0, 1'b0, 6'h20, 2, 1'b0, "R4");
      // R3, R10: LSB-first read with clock idle high
      frame(1'b1, 1'b0, 6'h21, 1, 1'b1, "R4");
      wq.push_back(8'hC4);
      frame(1'b0, 1'b0, 6'h10, 1, 1'b1, "R3");
      frame(1'b1, 1'b0, 6'h10, 1, 1'b1, "R3");
      frame(1'b1, 1'b0, 6'h05, 2, 1'b0, "R10");

      // R7: four-wire read
      wq.push_back(8'h03);
      frame(1'b0, 1'b0, 6'h20, 1, 1'b0, "R7");
      frame(1'b1, 1'b0, 6'h10, 2, 1'b0, "R7");
      frame(1'b1, 1'b0, 6'h3F, 2, 1'b1, "R7");

      // R3: back to MSB first and 3-wire
      wq.push_back(8'h00);
      frame(1'b0, 1'b0, 6'h20, 1, 1'b1, "R3");
      frame(1'b1, 1'b0, 6'h05, 2, 1'b0, "R3");
      chk(sdio_oe == 1'b0, "R6", "sdio_oe after frame", sdio_oe, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule